// File: doc/BRIEF.md
# Single-Leg Clamping PWM Modulator

This block turns three signed phase reference voltages into complementary gate signals for a two-level, three-phase voltage source inverter. It adds one common zero-sequence offset to all three references, so the line-to-line voltages delivered to the load are unchanged. The offset is chosen so that a single selected leg sits on a dc rail for part of each fundamental cycle and stops switching there. The other two legs keep switching continuously. A controller uses this to cut switching loss in one leg that is wearing faster than the others.

The clamp rail is picked in one of three ways. It can be a fixed rail. It can follow the sign of a third-harmonic cosine of the electrical angle, shifted by the load angle and a per-mode phase step. It can follow the phase currents, clamping toward the rail on the side of the larger current magnitude. A clamp is applied only while the selected leg holds the largest or the smallest reference, and only toward the rail that matches that position. Otherwise the offset falls back to the midpoint value. A shared up/down triangular carrier compares against the saturated modulation values. The references, the offset and the rail span are captured once per carrier period, at the carrier peak.

Top module: `leg_clamp_pwm`

## Requirements
- R1: Each modulation output equals its reference plus one offset common to all three phases, saturated to the range ±H, where H = floor(dcLink/2).
- R2: In mode 3'd0, the offset is always the midpoint value -floor((Vmax+Vmin)/2), where Vmax and Vmin are the largest and smallest of the three references.
- R3: In mode 3'd6 (upper rail), the offset is H-Vmax when the target phase reference equals Vmax. Otherwise it is the midpoint value.
- R4: In mode 3'd5 (lower rail), the offset is -H-Vmin when the target phase reference equals Vmin. Otherwise it is the midpoint value.
- R5: In modes 3'd1..3'd4, let t = angle+loadAngle+d modulo 2^AW, with d = +S, 0, -S, -2S for the four modes and S = floor((2^AW+6)/12), which is 30 degrees. Let x = 3t modulo 2^AW. The upper rail is chosen when bits AW-1 and AW-2 of x are equal, and the lower rail when they differ. The chosen rail is then applied as in R3 or R4.
- R6: In mode 3'd7, the upper rail is chosen when |max current| >= |min current| and the lower rail otherwise, each applied as in R3 or R4.
- R7: Target code 2'd3 selects no leg, so the offset is the midpoint value in every mode. Codes 2'd0, 2'd1 and 2'd2 select phases a, b and c.
- R8: The modulation outputs and the captured H change only at the carrier peak. Input changes between two peaks do not reach the outputs until the next peak.
- R9: The carrier counts 0 up to P-1, holds P-1 for one cycle, counts back down to 0, holds 0 for one cycle, and repeats, giving a period of 2P cycles. The values are captured on the edge that leaves the rising P-1 sample.
- R10: For each phase, upper = ((mod+H)·P > (2c+1)·H), where c is the carrier value, and lower is the complement of upper. A leg at +H is high for the whole period, and a leg at -H is low for the whole period.
- R11: After reset the carrier is 0, all modulation outputs are 0, every upper gate is 0 and every lower gate is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refA | input | DW | Phase a reference, signed |
| refB | input | DW | Phase b reference, signed |
| refC | input | DW | Phase c reference, signed |
| dcLink | input | DW | DC-link voltage, unsigned, same scale as references |
| angle | input | AW | Electrical angle, full turn = 2^AW |
| loadAngle | input | AW | Load angle, same scale as angle |
| curA | input | IW | Phase a current, signed |
| curB | input | IW | Phase b current, signed |
| curC | input | IW | Phase c current, signed |
| mode | input | 3 | Rail selection mode |
| target | input | 2 | Leg to clamp (3 = none) |
| carrier | output | CW | Triangular carrier value |
| modA | output | DW | Phase a modulation value, signed |
| modB | output | DW | Phase b modulation value, signed |
| modC | output | DW | Phase c modulation value, signed |
| upperGate | output | 3 | Upper switch gates, bit 0 = phase a |
| lowerGate | output | 3 | Lower switch gates, bit 0 = phase a |

## Verification
The hardest case to reach is a rail request that disagrees with where the target leg sits. An example is an upper-rail decision while the target holds the minimum reference. Here the block must refuse to clamp, even though a plain discontinuous modulator would clamp a different leg. The stimulus reaches it by fixing references with a known order and then choosing angles whose tripled value lands in each quadrant for every phase-shifted mode. It also swaps the signs of the phase currents, so that each rail decision meets both a matching and a mismatching target. Capture timing is checked by changing the references right after an observed peak and confirming the outputs hold until the following one.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
  localparam int NPH = 3;

  typedef enum logic [2:0] {
    MODE_MID    = 3'd0,
    MODE_SHIFTA = 3'd1,
    MODE_SHIFTB = 3'd2,
    MODE_SHIFTC = 3'd3,
    MODE_SHIFTD = 3'd4,
    MODE_LOWER  = 3'd5,
    MODE_UPPER  = 3'd6,
    MODE_CURR   = 3'd7
  } lcpMode_e;

  typedef struct packed {
    logic latch;
    logic wantUp;
    logic wantLo;
  } lcpCtl_t;
endpackage

// File: rtl/lcp_ctrl.sv
module lcp_ctrl
  import lcp_pkg::*;
#(
  parameter int AW = 16,
  parameter int IW = 16,
  parameter int CAR_STEPS = 5000,
  localparam int CW = $clog2(CAR_STEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           mode,
  input  logic [AW-1:0]        angle,
  input  logic [AW-1:0]        loadAngle,
  input  logic signed [IW-1:0] curIn [NPH],
  output lcpCtl_t              ctl,
  output logic [CW-1:0]        carrier
);
  localparam logic [AW-1:0] STEP30 = AW'(((2 ** AW) + 6) / 12);
  localparam logic [CW-1:0] TOP = CW'(CAR_STEPS - 1);

  logic rising;
  logic [AW-1:0] shiftVal, theta, triple;
  logic cosUpper;
  logic signed [IW-1:0] curMax, curMin;
  logic signed [IW:0] absMax, absMin, sMax, sMin;
  logic currUpper;

  // triangular carrier
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= '0;
      rising  <= 1'b1;
    end else if (rising) begin
      if (carrier == TOP) rising <= 1'b0;
      else                carrier <= carrier + 1'b1;
    end else begin
      if (carrier == '0) rising <= 1'b1;
      else               carrier <= carrier - 1'b1;
    end
  end

  // third-harmonic sign without trigonometry
  always_comb begin
    case (lcpMode_e'(mode))
      MODE_SHIFTA: shiftVal = STEP30;
      MODE_SHIFTC: shiftVal = -STEP30;
      MODE_SHIFTD: shiftVal = -(STEP30 << 1);
      default:     shiftVal = '0;
    endcase
    theta    = angle + loadAngle + shiftVal;
    triple   = theta + (theta << 1);
    cosUpper = (triple[AW-1] == triple[AW-2]);
  end

  // current-magnitude rail choice
  always_comb begin
    curMax = curIn[0];
    curMin = curIn[0];
    for (int k = 1; k < NPH; k++) begin
      if (curIn[k] > curMax) curMax = curIn[k];
      if (curIn[k] < curMin) curMin = curIn[k];
    end
    sMax = curMax;
    sMin = curMin;
    absMax = (sMax < 0) ? -sMax : sMax;
    absMin = (sMin < 0) ? -sMin : sMin;
    currUpper = (absMax >= absMin);
  end

  always_comb begin
    ctl.latch = rising && (carrier == TOP);
    case (lcpMode_e'(mode))
      MODE_MID:   begin ctl.wantUp = 1'b0;      ctl.wantLo = 1'b0;       end
      MODE_LOWER: begin ctl.wantUp = 1'b0;      ctl.wantLo = 1'b1;       end
      MODE_UPPER: begin ctl.wantUp = 1'b1;      ctl.wantLo = 1'b0;       end
      MODE_CURR:  begin ctl.wantUp = currUpper; ctl.wantLo = !currUpper; end
      default:    begin ctl.wantUp = cosUpper;  ctl.wantLo = !cosUpper;  end
    endcase
  end

  p_carrier_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    carrier <= TOP);
  p_carrier_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rising && carrier != TOP) |=> (carrier == $past(carrier) + 1'b1));
  p_one_rail_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.wantUp && ctl.wantLo));
endmodule

// File: rtl/lcp_datapath.sv
module lcp_datapath
  import lcp_pkg::*;
#(
  parameter int DW = 16,
  parameter int CAR_STEPS = 5000,
  localparam int CW = $clog2(CAR_STEPS + 1),
  localparam int EW = DW + 3,
  localparam int PW = DW + CW + 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lcpCtl_t                   ctl,
  input  logic [CW-1:0]             carrier,
  input  logic signed [DW-1:0]      refIn [NPH],
  input  logic [DW-1:0]             dcLink,
  input  logic [1:0]                target,
  output logic [NPH-1:0][DW-1:0]    modReg,
  output logic [NPH-1:0]            upper
);
  logic [DW-1:0] halfReg;
  logic signed [DW-1:0] vMax, vMin, tRef;
  logic signed [EW-1:0] halfNow, mxE, mnE, midOff, offset;
  logic signed [EW-1:0] sumE [NPH];
  logic [NPH-1:0][DW-1:0] satVal;
  logic tValid, clampUp, clampLo;

  always_comb begin
    vMax = refIn[0];
    vMin = refIn[0];
    for (int k = 1; k < NPH; k++) begin
      if (refIn[k] > vMax) vMax = refIn[k];
      if (refIn[k] < vMin) vMin = refIn[k];
    end
    tValid  = (target != 2'd3);
    tRef    = tValid ? refIn[target] : refIn[0];
    clampUp = tValid && ctl.wantUp && (tRef == vMax);
    clampLo = tValid && ctl.wantLo && (tRef == vMin);
    halfNow = $signed({3'b000, dcLink[DW-1:1]});
    mxE     = vMax;
    mnE     = vMin;
    midOff  = -((mxE + mnE) >>> 1);
    if (clampUp)      offset = halfNow - mxE;
    else if (clampLo) offset = -halfNow - mnE;
    else              offset = midOff;
    for (int k = 0; k < NPH; k++) begin
      sumE[k] = EW'(refIn[k]) + offset;
      if (sumE[k] > halfNow)       satVal[k] = halfNow[DW-1:0];
      else if (sumE[k] < -halfNow) satVal[k] = DW'(-halfNow);
      else                         satVal[k] = sumE[k][DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modReg  <= '0;
      halfReg <= '0;
    end else if (ctl.latch) begin
      modReg  <= satVal;
      halfReg <= dcLink >> 1;
    end
  end

  p_hold_between_peaks_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.latch) |-> ($stable(modReg) && $stable(halfReg)));

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    logic [DW:0] shifted;
    logic [PW-1:0] lhs, rhs;
    always_comb begin
      shifted  = DW'(modReg[k]) + {1'b0, halfReg};
      shifted  = $unsigned($signed({modReg[k][DW-1], modReg[k]}) + $signed({1'b0, halfReg}));
      lhs      = PW'(shifted) * PW'(CAR_STEPS);
      rhs      = (PW'(carrier) * PW'(2) + PW'(1)) * PW'(halfReg);
      upper[k] = (lhs > rhs);
    end

    p_range_r1: assert property (@(posedge clk) disable iff (!rstN)
      ($signed(modReg[k]) <= $signed({1'b0, halfReg})) &&
      ($signed(modReg[k]) >= -$signed({1'b0, halfReg})));
    p_rail_high_r10: assert property (@(posedge clk) disable iff (!rstN)
      (halfReg != '0 && $signed(modReg[k]) == $signed({1'b0, halfReg})) |-> upper[k]);
    p_rail_low_r10: assert property (@(posedge clk) disable iff (!rstN)
      ($signed(modReg[k]) == -$signed({1'b0, halfReg})) |-> !upper[k]);
  end
endmodule

// File: rtl/leg_clamp_pwm.sv
module leg_clamp_pwm
  import lcp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int IW = 16,
  parameter int CAR_STEPS = 5000,
  localparam int CW = $clog2(CAR_STEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [DW-1:0] refA,
  input  logic signed [DW-1:0] refB,
  input  logic signed [DW-1:0] refC,
  input  logic [DW-1:0]        dcLink,
  input  logic [AW-1:0]        angle,
  input  logic [AW-1:0]        loadAngle,
  input  logic signed [IW-1:0] curA,
  input  logic signed [IW-1:0] curB,
  input  logic signed [IW-1:0] curC,
  input  logic [2:0]           mode,
  input  logic [1:0]           target,
  output logic [CW-1:0]        carrier,
  output logic signed [DW-1:0] modA,
  output logic signed [DW-1:0] modB,
  output logic signed [DW-1:0] modC,
  output logic [2:0]           upperGate,
  output logic [2:0]           lowerGate
);
  lcpCtl_t ctl;
  logic signed [DW-1:0] refArr [NPH];
  logic signed [IW-1:0] curArr [NPH];
  logic [NPH-1:0][DW-1:0] modPk;
  logic [NPH-1:0] upper;

  assign refArr = '{refA, refB, refC};
  assign curArr = '{curA, curB, curC};

  lcp_ctrl #(.AW(AW), .IW(IW), .CAR_STEPS(CAR_STEPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .angle(angle), .loadAngle(loadAngle),
    .curIn(curArr), .ctl(ctl), .carrier(carrier)
  );

  lcp_datapath #(.DW(DW), .CAR_STEPS(CAR_STEPS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .carrier(carrier), .refIn(refArr),
    .dcLink(dcLink), .target(target), .modReg(modPk), .upper(upper)
  );

  assign modA      = $signed(modPk[0]);
  assign modB      = $signed(modPk[1]);
  assign modC      = $signed(modPk[2]);
  assign upperGate = upper;
  assign lowerGate = ~upper;
endmodule

// File: tb/tb_leg_clamp_pwm.sv
module tb_leg_clamp_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;
  localparam int CW = $clog2(P + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [15:0] refA = 0, refB = 0, refC = 0;
  logic [15:0] dcLink = 0, angle = 0, loadAngle = 0;
  logic signed [15:0] curA = 0, curB = 0, curC = 0;
  logic [2:0] mode = 0;
  logic [1:0] target = 3;
  logic [CW-1:0] carrier;
  logic signed [15:0] modA, modB, modC;
  logic [2:0] upperGate, lowerGate;

  int total = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  leg_clamp_pwm #(.CAR_STEPS(P)) dut (
    .clk(clk), .rstN(rstN), .refA(refA), .refB(refB), .refC(refC),
    .dcLink(dcLink), .angle(angle), .loadAngle(loadAngle),
    .curA(curA), .curB(curB), .curC(curC), .mode(mode), .target(target),
    .carrier(carrier), .modA(modA), .modB(modB), .modC(modC),
    .upperGate(upperGate), .lowerGate(lowerGate)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clip(int v, int h);
    if (v > h) return h;
    if (v < -h) return -h;
    return v;
  endfunction

  // expected modulation values from the requirements
  task automatic expect3(output int e0, output int e1, output int e2);
    int r[3], c[3];
    int h, mx, mn, mid, off, th, x, d, cmx, cmn;
    bit up, lo;
    r = '{int'(refA), int'(refB), int'(refC)};
    c = '{int'(curA), int'(curB), int'(curC)};
    h = int'(dcLink) / 2;
    mx = r[0]; mn = r[0];
    cmx = c[0]; cmn = c[0];
    for (int k = 1; k < 3; k++) begin
      if (r[k] > mx) mx = r[k];
      if (r[k] < mn) mn = r[k];
      if (c[k] > cmx) cmx = c[k];
      if (c[k] < cmn) cmn = c[k];
    end
    mid = -((mn + mx) >>> 1);
    up = 0; lo = 0;
    case (mode)
      3'd5: lo = 1;
      3'd6: up = 1;
      3'd7: begin
        up = ((cmx < 0 ? -cmx : cmx) >= (cmn < 0 ? -cmn : cmn));
        lo = !up;
      end
      3'd1, 3'd2, 3'd3, 3'd4: begin
        d = (mode == 1) ? 5461 : (mode == 2) ? 0 : (mode == 3) ? -5461 : -10922;
        th = (int'(angle) + int'(loadAngle) + d) & 16'hFFFF;
        x = (3 * th) & 16'hFFFF;
        up = (((x >> 15) & 1) == ((x >> 14) & 1));
        lo = !up;
      end
      default: ;
    endcase
    off = mid;
    if (target != 3 && up && r[target] == mx) off = h - mx;
    else if (target != 3 && lo && r[target] == mn) off = -h - mn;
    e0 = clip(r[0] + off, h);
    e1 = clip(r[1] + off, h);
    e2 = clip(r[2] + off, h);
  endtask

  task automatic settleAndCheck(string req);
    int e0, e1, e2;
    expect3(e0, e1, e2);
    repeat (2 * P + 2) @(posedge clk);
    @(negedge clk);
    chk({req, " modA"}, modA, e0);
    chk({req, " modB"}, modB, e1);
    chk({req, " modC"}, modC, e2);
  endtask

  task automatic setRefs(int a, int b, int c);
    @(negedge clk);
    refA = 16'(a); refB = 16'(b); refC = 16'(c);
  endtask

  task automatic waitPeak();
    int prev;
    prev = -1;
    forever begin
      @(negedge clk);
      if (prev == P - 1 && int'(carrier) == P - 1) break;
      prev = int'(carrier);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R11 carrier", int'(carrier), 0);
    chk("R11 modA", modA, 0);
    chk("R11 upper", int'(upperGate), 0);
    chk("R11 lower", int'(lowerGate), 7);
  endtask

  task automatic t_mid();
    mode = 0; target = 0;
    setRefs(800, -300, -500);
    settleAndCheck("R2");            // -150 offset: 650,-450,-650
    chk("R2 explicit", modA, 650);
  endtask

  task automatic t_saturate();
    mode = 0; target = 3;
    setRefs(1200, 0, -1200);
    settleAndCheck("R1 sat");
    chk("R1 upper rail", modA, 1000);
    chk("R1 lower rail", modC, -1000);
  endtask

  task automatic t_upper();
    setRefs(800, -300, -500);
    mode = 6; target = 0;
    settleAndCheck("R3 match");
    chk("R3 clamp", modA, 1000);
    target = 1;
    settleAndCheck("R3 no match");
    chk("R3 mid", modB, -450);
  endtask

  task automatic t_lower();
    mode = 5; target = 2;
    settleAndCheck("R4 match");
    chk("R4 clamp", modC, -1000);
    target = 0;
    settleAndCheck("R4 no match");
  endtask

  task automatic t_shifted();
    for (int m = 1; m <= 4; m++) begin
      mode = 3'(m);
      for (int t = 0; t < 3; t += 2) begin
        target = 2'(t);
        angle = 16'h1000; settleAndCheck("R5 a1000");
        angle = 16'h2000; settleAndCheck("R5 a2000");
      end
    end
    mode = 2; target = 0; angle = 0; loadAngle = 16'h2000;
    settleAndCheck("R5 load angle");
    loadAngle = 0;
    settleAndCheck("R5 zero angle");
    chk("R5 peak clamp", modA, 1000);
  endtask

  task automatic t_current();
    mode = 7;
    curA = 100; curB = -400; curC = 300;
    target = 2; settleAndCheck("R6 lower"); chk("R6 lower clamp", modC, -1000);
    target = 0; settleAndCheck("R6 lower mismatch");
    curA = 400; curB = -100; curC = -300;
    target = 0; settleAndCheck("R6 upper"); chk("R6 upper clamp", modA, 1000);
  endtask

  task automatic t_none();
    target = 3;
    for (int m = 5; m <= 7; m++) begin
      mode = 3'(m);
      settleAndCheck("R7 none");
      chk("R7 mid value", modA, 650);
    end
  endtask

  task automatic t_latch();
    mode = 0; target = 3;
    setRefs(800, -300, -500);
    settleAndCheck("R8 base");
    waitPeak();
    refA = 100; refB = 0; refC = -100;
    repeat (P) @(negedge clk);
    chk("R8 held A", modA, 650);
    chk("R8 held C", modC, -650);
    repeat (P + 2) @(negedge clk);
    chk("R8 updated A", modA, 100);
    chk("R8 updated C", modC, -100);
  endtask

  task automatic t_carrier();
    int n, mx, bad, prev;
    waitPeak();
    n = 0; mx = 0; bad = 0; prev = P - 1;
    forever begin
      @(negedge clk);
      n++;
      if (int'(carrier) > mx) mx = int'(carrier);
      if (int'(carrier) - prev > 1 || prev - int'(carrier) > 1) bad++;
      if (prev == P - 1 && int'(carrier) == P - 1) break;
      prev = int'(carrier);
      if (n > 4 * P) break;
    end
    chk("R9 period", n, 2 * P);
    chk("R9 max", mx, P - 1);
    chk("R9 step", bad, 0);
  endtask

  task automatic t_gates();
    int hi[3], mis, cmp;
    mode = 6; target = 0;
    setRefs(800, -300, -500);
    settleAndCheck("R10 setup");      // 1000, -100, -300
    hi = '{0, 0, 0}; mis = 0; cmp = 0;
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        int mv;
        mv = (k == 0) ? modA : (k == 1) ? modB : modC;
        if (upperGate[k]) hi[k]++;
        if (upperGate[k] == lowerGate[k]) cmp++;
        if (upperGate[k] != (((mv + 1000) * P) > ((2 * int'(carrier) + 1) * 1000))) mis++;
      end
    end
    chk("R10 rail leg high", hi[0], 2 * P);
    chk("R10 leg b duty", hi[1], 8);
    chk("R10 leg c duty", hi[2], 6);
    chk("R10 compare", mis, 0);
    chk("R10 complement", cmp, 0);
  endtask

  initial begin
    dcLink = 2000;
    t_reset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_mid();
    t_saturate();
    t_upper();
    t_lower();
    t_shifted();
    t_current();
    t_none();
    t_latch();
    t_carrier();
    t_gates();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule